// File: doc/BRIEF.md
# Paged Memory Management Unit

This block extends the reach of an 8-bit processor with a 16-bit logical address to a 1MB physical space. The logical space is cut into sixteen 4K pages. The top four logical address bits select one of sixteen page-table entries. That entry supplies the upper eight bits of a 20-bit physical address, and the twelve in-page offset bits pass through unchanged. Translation is purely combinational, so a memory cycle needs no wait states.

Software fills the table with I/O write cycles to a fixed port. Port decoding looks only at logical address bits 7:6, which must both be 1. The entry to write is taken from address bits 15:12, so the processor has to place the entry number in the high nibble of the register that drives the upper address byte. The value comes from the data bus.

Each decoded cycle writes exactly once, on its first clock. The table is never initialised, so boot code must run from a region that does not go through the table until every entry has been written. The block has no flow control. Translation is a combinational path that is valid whenever the address is. A write strobe is taken whenever it is presented, and nothing can hold it off.

Top module: `paged_mmu`

## Requirements
- R1: phys_addr[11:0] always equals cpu_addr[11:0].
- R2: phys_addr[19:12] equals the table entry indexed by cpu_addr[15:12].
- R3: A table write is decoded when iorq_n=0, m1_n=1, wr_n=0 and cpu_addr[7:6]=2'b11. It stores cpu_data into the entry indexed by cpu_addr[15:12], and map_wr is 1 in that clock.
- R4: A decoded write held for several clocks produces a single map_wr pulse, in its first clock. A new pulse needs at least one clock without a decoded write first.
- R5: With m1_n=0 (interrupt acknowledge), no write happens and map_wr stays 0.
- R6: An I/O read (wr_n=1) and any cycle with iorq_n=1 cause no write, and map_wr stays 0.
- R7: cpu_addr[7:6] other than 2'b11 causes no write. cpu_addr[5:0] and cpu_addr[11:8] do not affect the decode.
- R8: Translation responds to a change of cpu_addr within the same clock period, with no clock edge needed.
- R9: A written value is seen by translation from the clock edge that ends the pulse. Entries that were not written keep their values, and a later write to the same entry replaces the earlier value.
- R10: While rst_n=0, map_wr is 0. A decoded write that is already active when reset is released is not taken; it must end and start again. Table contents are not initialised by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write-strobe edge detector |
| cpu_addr | input | 16 | Logical address bus |
| cpu_data | input | 8 | Processor data bus, the source of table writes |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch / interrupt-acknowledge flag, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_addr | output | 20 | Translated physical address |
| map_wr | output | 1 | One-clock pulse when a table entry is written |

## Verification
On every clock, the assertions check that map_wr never rises during an interrupt acknowledge, an I/O read, a memory cycle or a non-matching port. They also check that a pulse never lasts two clocks, and that the entry just written shows up on the translation output when the same page is addressed next. What only the scenarios can show is the following. A write strobe held across reset release is rejected. The in-page offset and the page lookup follow an address change within one clock period. Blocked cycles and writes to other pages leave an entry unchanged, which is read back through translation.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  // Decoded I/O cycle control, active-low pins as seen on the bus.
  typedef struct packed {
    logic iorq_n;
    logic m1_n;
    logic wr_n;
  } io_ctl_t;

  // True for an I/O write outside an interrupt acknowledge.
  function automatic logic io_write_cycle(input io_ctl_t c);
    return (!c.iorq_n) && c.m1_n && (!c.wr_n);
  endfunction
endpackage

// File: rtl/mmu_io_decode.sv
module mmu_io_decode #(
  parameter int IDX_W   = 4,
  parameter int PSEL_W  = 2,
  parameter logic [PSEL_W-1:0] PSEL_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mmu_pkg::io_ctl_t  ctl,
  input  logic [PSEL_W-1:0] port_sel,
  input  logic [IDX_W-1:0]  page_idx,
  output logic              wr_pulse,
  output logic [IDX_W-1:0]  wr_idx
);
  logic hit;
  logic hit_q;

  assign hit = mmu_pkg::io_write_cycle(ctl) && (port_sel == PSEL_VAL);

  // Resets to 1 so a strobe already present at reset release is not taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b1;
    else        hit_q <= hit;
  end

  assign wr_pulse = hit && !hit_q;
  assign wr_idx   = page_idx;
endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table #(
  parameter int IDX_W   = 4,
  parameter int ENT_W   = 8,
  parameter int SLICE_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NSLICE = ENT_W / SLICE_W;

  // The entry is built from narrow register files side by side; none is reset.
  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    logic [SLICE_W-1:0] rf [DEPTH];

    always_ff @(posedge clk) begin
      if (we) rf[widx] <= wdata[s*SLICE_W +: SLICE_W];
    end

    assign rdata[s*SLICE_W +: SLICE_W] = rf[ridx];
  end
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu #(
  parameter int LOG_W   = 16,
  parameter int IDX_W   = 4,
  parameter int ENT_W   = 8,
  parameter int SLICE_W = 4,
  parameter int PSEL_HI = 7,
  parameter int PSEL_LO = 6,
  parameter logic [PSEL_HI-PSEL_LO:0] PSEL_VAL = '1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LOG_W-1:0]               cpu_addr,
  input  logic [ENT_W-1:0]               cpu_data,
  input  logic                           iorq_n,
  input  logic                           m1_n,
  input  logic                           wr_n,
  output logic [LOG_W-IDX_W+ENT_W-1:0]   phys_addr,
  output logic                           map_wr
);
  localparam int OFF_W  = LOG_W - IDX_W;
  localparam int PSEL_W = PSEL_HI - PSEL_LO + 1;

  mmu_pkg::io_ctl_t ctl;
  logic [IDX_W-1:0] page_idx;
  logic [IDX_W-1:0] wr_idx;
  logic [ENT_W-1:0] frame;

  assign ctl      = '{iorq_n: iorq_n, m1_n: m1_n, wr_n: wr_n};
  assign page_idx = cpu_addr[LOG_W-1:OFF_W];

  mmu_io_decode #(
    .IDX_W   (IDX_W),
    .PSEL_W  (PSEL_W),
    .PSEL_VAL(PSEL_VAL)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .port_sel(cpu_addr[PSEL_HI:PSEL_LO]),
    .page_idx(page_idx),
    .wr_pulse(map_wr),
    .wr_idx  (wr_idx)
  );

  mmu_page_table #(
    .IDX_W  (IDX_W),
    .ENT_W  (ENT_W),
    .SLICE_W(SLICE_W)
  ) u_tbl (
    .clk  (clk),
    .we   (map_wr),
    .widx (wr_idx),
    .wdata(cpu_data),
    .ridx (page_idx),
    .rdata(frame)
  );

  assign phys_addr = {frame, cpu_addr[OFF_W-1:0]};
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk #(
  parameter int IDX_W  = 4,
  parameter int ENT_W  = 8,
  parameter int PSEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  idx,
  input logic [PSEL_W-1:0] psel,
  input logic [ENT_W-1:0]  data,
  input logic [ENT_W-1:0]  frame,
  input logic              iorq_n,
  input logic              m1_n,
  input logic              wr_n,
  input logic              map_wr
);
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> !map_wr);

  // R5
  no_ack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_n |-> !map_wr);

  // R6
  no_read_or_mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || wr_n) |-> !map_wr);

  // R7
  port_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel != '1) |-> !map_wr);

  // R9
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> ((idx != $past(idx)) || (frame == $past(data))));
endmodule

bind paged_mmu mmu_chk #(
  .IDX_W (IDX_W),
  .ENT_W (ENT_W),
  .PSEL_W(PSEL_HI - PSEL_LO + 1)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .idx   (cpu_addr[LOG_W-1:LOG_W-IDX_W]),
  .psel  (cpu_addr[PSEL_HI:PSEL_LO]),
  .data  (cpu_data),
  .frame (phys_addr[LOG_W-IDX_W+ENT_W-1:LOG_W-IDX_W]),
  .iorq_n(iorq_n),
  .m1_n  (m1_n),
  .wr_n  (wr_n),
  .map_wr(map_wr)
);

// File: tb/tb_paged_mmu.sv
module tb_paged_mmu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // {addr[15:0], data[7:0], iorq_n, m1_n, wr_n, expected map_wr}
  localparam logic [27:0] VEC [NVEC] = '{
    {16'h30C0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 basic write, page 3
    {16'h5FC0, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 page 5, bits 11:8 ignored
    {16'h50FF, 8'h99, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 low bits ignored, overwrite page 5
    {16'h5080, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 port bits 10
    {16'h5040, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 port bits 01
    {16'h5000, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 port bits 00
    {16'h50C0, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 interrupt acknowledge
    {16'h50C0, 8'h22, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 I/O read
    {16'h50C0, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 memory write
    {16'hF0C0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 top page
    {16'h00C3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}   // R3 page 0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        iorq_n = 1'b1;
  logic        m1_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [19:0] phys_addr;
  logic        map_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] mdl [16];
  bit         mval [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_mmu dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .m1_n(m1_n), .wr_n(wr_n),
    .phys_addr(phys_addr), .map_wr(map_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    iorq_n = 1'b1; m1_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic drive_write(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_data = d; iorq_n = 1'b0; m1_n = 1'b1; wr_n = 1'b0;
  endtask

  // Check translation of a given page/offset against the model (R1, R2).
  task automatic chk_xlate(input logic [3:0] pg, input logic [11:0] off);
    cpu_addr = {pg, off};
    #1;
    chk("R1 offset", {20'd0, phys_addr[11:0]}, {20'd0, off});
    if (mval[pg]) chk("R2 frame", {24'd0, phys_addr[19:12]}, {24'd0, mdl[pg]});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pulses;
    for (int i = 0; i < 16; i++) mval[i] = 1'b0;

    // R10: a decoded write present during reset and at its release is not taken.
    drive_write(16'h90C0, 8'h42);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R10 reset", {31'd0, map_wr}, 32'd0);
    end
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R10 held at release", {31'd0, map_wr}, 32'd0);
    @(negedge clk); #1;
    chk("R10 held after release", {31'd0, map_wr}, 32'd0);
    go_idle();
    @(negedge clk);
    drive_write(16'h90C0, 8'h42); #1;
    chk("R10 re-strobe", {31'd0, map_wr}, 32'd1);
    mdl[9] = 8'h42; mval[9] = 1'b1;
    @(negedge clk); go_idle();
    chk_xlate(4'h9, 12'h0C0);

    // Vector table walk: R3, R5, R6, R7, R9.
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      cpu_addr = VEC[v][27:12]; cpu_data = VEC[v][11:4];
      iorq_n = VEC[v][3]; m1_n = VEC[v][2]; wr_n = VEC[v][1];
      #1;
      chk($sformatf("R3/R5/R6/R7 vec%0d map_wr", v), {31'd0, map_wr}, {31'd0, VEC[v][0]});
      if (VEC[v][0]) begin
        mdl[VEC[v][27:24]] = VEC[v][11:4];
        mval[VEC[v][27:24]] = 1'b1;
      end
      @(negedge clk);
      go_idle();
      #1;
      chk($sformatf("R9 vec%0d frame", v), {24'd0, phys_addr[19:12]},
          {24'd0, mdl[VEC[v][27:24]]});
    end

    // R9: untouched entries and overwritten entry read back.
    @(negedge clk);
    chk_xlate(4'h3, 12'hABC);
    chk_xlate(4'h5, 12'h001);
    chk_xlate(4'hF, 12'hFFF);
    chk_xlate(4'h0, 12'h800);

    // R4: strobe held three clocks gives one pulse.
    @(negedge clk);
    drive_write(16'h2DC0, 8'h24);
    pulses = 0;
    for (int i = 0; i < 3; i++) begin
      #1;
      if (map_wr) pulses++;
      @(negedge clk);
    end
    go_idle();
    chk("R4 pulse count", pulses, 32'd1);
    mdl[2] = 8'h24; mval[2] = 1'b1;
    chk_xlate(4'h2, 12'h345);

    // R8: translation follows the address inside one clock period.
    @(negedge clk);
    cpu_addr = 16'h3123; #1;
    chk("R8 first addr", {12'd0, phys_addr}, {12'd0, 8'hA5, 12'h123});
    #1 cpu_addr = 16'h5456; #1;
    chk("R8 second addr", {12'd0, phys_addr}, {12'd0, 8'h99, 12'h456});
    #1 cpu_addr = 16'h9789; #1;
    chk("R8 third addr", {12'd0, phys_addr}, {12'd0, 8'h42, 12'h789});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule